// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Error Status

This block sits behind a serial receiver's deserializer and buffers incoming characters until software or a bus master collects them. Each character arrives as a 9-bit data word with three error bits (parity, noise, framing). The block stores all twelve bits together, so the error status stays attached to its own character. The oldest character sits in a read holding register. Its data appears on `rd_data` and its error bits appear on three separate status outputs.

The queue has a 7-deep store behind the holding register, for 8 characters in total. A 3-bit code selects a fill level. A level-sensitive flag reports when the number of characters held reaches that level, and the count includes the character in the holding register. An interrupt line follows the flag when the interrupt enable is set. When queueing is disabled, the block collapses to the holding register alone.

Top module: `rx_err_fifo`

## Requirements
- R1: After a synchronous reset, `empty` is 1, `full`, `overrun`, `thr_flag` and `irq` are 0, and `rd_data` and the three head error outputs are 0.
- R2: Characters are delivered in arrival order. Each one is stored as a 12-bit entry ordered data[8:0], parity, noise, framing. `rd_data` shows only the data of the oldest character, and `hd_perr`/`hd_nerr`/`hd_ferr` show that same character's error bits.
- R3: With `cfg_fifo_en`=1 the block holds up to 8 characters. `full` is 1 exactly when 8 are held.
- R4: A character that arrives while all places are occupied and no read is accepted in the same cycle is dropped. The stored characters are unchanged and `overrun` becomes 1. Filling the 8th place does not set `overrun`. `overrun` clears when a read is accepted.
- R5: `thr_flag` is 1 while the number of characters held is at least the level selected by `cfg_thr_code`: 0→1, 1→2, 2→4, 3→6, 4→7, 5→8, 6→8, 7→8. The flag drops as soon as reads bring the count below that level.
- R6: `irq` equals `thr_flag` AND `cfg_irq_en`.
- R7: With `cfg_fifo_en`=0 the capacity is 1 character and the level is 1 whatever the code. A second character that arrives while one is held sets `overrun` and is dropped.
- R8: A read (`rd_en`=1) while `empty` is 1 changes no state, and `rd_data` keeps its last value.
- R9: A write and a read accepted in the same cycle while 8 characters are held both take effect: the oldest character leaves, the new one is queued and `overrun` stays 0.
- R10: A character written while the block is empty appears on `rd_data` and the head error outputs, and `empty` falls, in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_en | input | 1 | 1: 8-character queue, 0: single holding register |
| cfg_thr_code | input | 3 | Fill-level code for `thr_flag` |
| cfg_irq_en | input | 1 | Lets `thr_flag` drive `irq` |
| wr_valid | input | 1 | Incoming character strobe |
| wr_data | input | 9 | Incoming data word |
| wr_perr | input | 1 | Parity error of the incoming character |
| wr_nerr | input | 1 | Noise error of the incoming character |
| wr_ferr | input | 1 | Framing error of the incoming character |
| rd_en | input | 1 | Consume the character in the holding register |
| rd_data | output | 9 | Data of the holding register |
| hd_perr | output | 1 | Parity error of the head character |
| hd_nerr | output | 1 | Noise error of the head character |
| hd_ferr | output | 1 | Framing error of the head character |
| thr_flag | output | 1 | Fill level reached |
| empty | output | 1 | No character held |
| full | output | 1 | Capacity reached |
| overrun | output | 1 | A character was dropped |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a write and a read landing in the same cycle while every place is occupied. The new character must pass through the queue store while the head moves into the holding register. The bench fills all 8 places first, drives both strobes in one cycle, and then drains the queue to confirm the order. A sweep over all eight codes, with the interrupt enable both off and on, steps the fill level from 0 to 8 and back to 0 and compares the flag at every count. A pseudo-random run of mixed strobes then exercises the wrap of the store pointers.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Number of error bits stored beside each data word
  localparam int unsigned ERR_W = 3;

  typedef struct packed {
    logic perr;
    logic nerr;
    logic ferr;
  } rx_err_t;

  // Fill level selected by a 3-bit code, scaled to the total capacity
  function automatic int unsigned thr_level(input logic [2:0] code,
                                            input int unsigned cap);
    case (code)
      3'd0:    return 1;
      3'd1:    return cap / 4;
      3'd2:    return cap / 2;
      3'd3:    return (3 * cap) / 4;
      3'd4:    return cap - 1;
      default: return cap;
    endcase
  endfunction

endpackage

// File: rtl/rxq_queue.sv
module rxq_queue #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 7,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] cnt
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // Storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R3: a push with no pop never goes past the store depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (cnt < CW'(DEPTH)));

  // R8: the store is never popped while it is empty
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));

endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int unsigned CAP = 8,
  localparam int unsigned CW = $clog2(CAP + 1)
) (
  input  logic [CW-1:0] total,
  input  logic          fifo_en,
  input  logic [2:0]    code,
  input  logic          irq_en,
  output logic          thr_flag,
  output logic          irq,
  output logic          empty,
  output logic          full
);

  logic [CW-1:0] lvl;
  logic [CW-1:0] cap_eff;

  always_comb begin
    lvl     = fifo_en ? CW'(rxq_pkg::thr_level(code, CAP)) : CW'(1);
    cap_eff = fifo_en ? CW'(CAP) : CW'(1);
  end

  assign thr_flag = (total >= lvl);
  assign irq      = thr_flag & irq_en;
  assign empty    = (total == '0);
  assign full     = (total == cap_eff);

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int unsigned DATA_W  = 9,
  parameter int unsigned Q_DEPTH = 7,
  localparam int unsigned ENT_W  = DATA_W + rxq_pkg::ERR_W,
  localparam int unsigned CAP    = Q_DEPTH + 1,
  localparam int unsigned CW     = $clog2(CAP + 1),
  localparam int unsigned QCW    = $clog2(Q_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_fifo_en,
  input  logic [2:0]        cfg_thr_code,
  input  logic              cfg_irq_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_perr,
  input  logic              wr_nerr,
  input  logic              wr_ferr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              hd_perr,
  output logic              hd_nerr,
  output logic              hd_ferr,
  output logic              thr_flag,
  output logic              empty,
  output logic              full,
  output logic              overrun,
  output logic              irq
);

  import rxq_pkg::*;

  // Holding register: data plus error bits of the oldest character
  logic [DATA_W-1:0] hr_data;
  rx_err_t           hr_err;
  logic              hr_v;

  logic [ENT_W-1:0] in_ent, q_head;
  logic [QCW-1:0]   q_cnt;
  logic [CW-1:0]    total_cnt;
  logic             pop, q_has, accept, wr_to_hr, q_push, q_pop;

  assign in_ent    = {wr_data, wr_perr, wr_nerr, wr_ferr};
  assign total_cnt = CW'(hr_v) + CW'(q_cnt);
  assign q_has     = (q_cnt != '0);

  // A read is only taken when a character is held
  assign pop      = rd_en & hr_v;
  assign accept   = wr_valid & (~full | pop);
  assign q_pop    = pop & q_has;
  assign wr_to_hr = accept & (~hr_v | pop) & ~q_has;
  assign q_push   = accept & ~wr_to_hr;

  rxq_queue #(.W(ENT_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (q_push),
    .push_data (in_ent),
    .pop       (q_pop),
    .head_data (q_head),
    .cnt       (q_cnt)
  );

  rxq_level #(.CAP(CAP)) u_level (
    .total    (total_cnt),
    .fifo_en  (cfg_fifo_en),
    .code     (cfg_thr_code),
    .irq_en   (cfg_irq_en),
    .thr_flag (thr_flag),
    .irq      (irq),
    .empty    (empty),
    .full     (full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_data <= '0;
      hr_err  <= '0;
      hr_v    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (q_pop) begin
        hr_data <= q_head[ENT_W-1:ERR_W];
        hr_err  <= rx_err_t'(q_head[ERR_W-1:0]);
        hr_v    <= 1'b1;
      end else if (wr_to_hr) begin
        hr_data <= wr_data;
        hr_err  <= rx_err_t'({wr_perr, wr_nerr, wr_ferr});
        hr_v    <= 1'b1;
      end else if (pop) begin
        hr_v    <= 1'b0;
      end
      if (pop)
        overrun <= 1'b0;
      else if (wr_valid && !accept)
        overrun <= 1'b1;
    end
  end

  assign rd_data = hr_data;
  assign hd_perr = hr_err.perr;
  assign hd_nerr = hr_err.nerr;
  assign hd_ferr = hr_err.ferr;

  // R3: the number held never exceeds the capacity
  p_capacity_r3: assert property (@(posedge clk) disable iff (rst)
    total_cnt <= CW'(CAP));

  // R4: a dropped character leaves the count alone and raises overrun
  p_drop_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && full && !rd_en) |=> (overrun && total_cnt == $past(total_cnt)));

  // R8: a read on an empty block with no write changes nothing
  p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_valid) |=> ($stable(rd_data) && empty && $stable(overrun)));

  // R6: an interrupt implies something is held
  p_irq_needs_data_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> !empty);

  // R9: a write together with an accepted read never sets overrun
  p_swap_no_ovr_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && rd_en && !empty) |=> !overrun);

endmodule

// File: tb/test_rx_err_fifo.sv
module test_rx_err_fifo;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_fifo_en = 1'b1;
  logic [2:0] cfg_thr_code = 3'd0;
  logic       cfg_irq_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_perr = 1'b0, wr_nerr = 1'b0, wr_ferr = 1'b0;
  logic       rd_en = 1'b0;
  logic [8:0] rd_data;
  logic       hd_perr, hd_nerr, hd_ferr;
  logic       thr_flag, empty, full, overrun, irq;

  always #10 clk = ~clk;

  rx_err_fifo i_rx_err_fifo (
    .clk(clk), .rst(rst), .cfg_fifo_en(cfg_fifo_en), .cfg_thr_code(cfg_thr_code),
    .cfg_irq_en(cfg_irq_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_perr(wr_perr), .wr_nerr(wr_nerr), .wr_ferr(wr_ferr), .rd_en(rd_en),
    .rd_data(rd_data), .hd_perr(hd_perr), .hd_nerr(hd_nerr), .hd_ferr(hd_ferr),
    .thr_flag(thr_flag), .empty(empty), .full(full), .overrun(overrun), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [11:0] mq[$];
  logic [11:0] m_last = '0;
  bit          m_ovr = 0;
  int          seq = 0;

  function automatic int m_cap();
    return cfg_fifo_en ? 8 : 1;
  endfunction

  function automatic int m_thr();
    if (!cfg_fifo_en) return 1;
    case (cfg_thr_code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 6;
      3'd4: return 7;
      default: return 8;
    endcase
  endfunction

  function automatic logic [11:0] next_ent();
    seq++;
    return {9'(seq * 37 + 11), 3'(seq * 5)};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [11:0] h;
    int n;
    bit t;
    n = mq.size();
    h = (n > 0) ? mq[0] : m_last;
    t = (n >= m_thr());
    chk(tag, "rd_data", int'(rd_data), int'(h[11:3]));
    chk(tag, "head_err", int'({hd_perr, hd_nerr, hd_ferr}), int'(h[2:0]));
    chk(tag, "empty", int'(empty), int'(n == 0));
    chk(tag, "full", int'(full), int'(n == m_cap()));
    chk(tag, "overrun", int'(overrun), int'(m_ovr));
    chk(tag, "thr_flag", int'(thr_flag), int'(t));
    chk(tag, "irq", int'(irq), int'(t && cfg_irq_en));
  endtask

  task automatic cycle(input bit wr, input logic [11:0] ent, input bit rd);
    bit pop, acc;
    wr_valid = wr;
    {wr_data, wr_perr, wr_nerr, wr_ferr} = ent;
    rd_en = rd;
    @(posedge clk);
    #1;
    pop = rd && (mq.size() > 0);
    acc = wr && ((mq.size() < m_cap()) || pop);
    if (pop) begin
      m_last = mq.pop_front();
      m_ovr = 0;
    end
    if (acc) mq.push_back(ent);
    else if (wr) m_ovr = 1;
    wr_valid = 1'b0;
    rd_en = 1'b0;
  endtask

  task automatic drain(input string tag);
    while (mq.size() > 0) begin
      cycle(0, '0, 1);
      check_all(tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check_all("R1");

    // R10: single character becomes visible one cycle after its write
    cycle(1, next_ent(), 0);
    check_all("R10");
    drain("R2");

    // R5 / R6: level sweep over every code, interrupt enable off and on
    for (int ie = 0; ie < 2; ie++) begin
      for (int code = 0; code < 8; code++) begin
        cfg_thr_code = 3'(code);
        cfg_irq_en = ie[0];
        #1;
        check_all(ie ? "R6" : "R5");
        for (int k = 1; k <= 8; k++) begin
          cycle(1, next_ent(), 0);
          check_all(k == 8 ? "R3" : (ie ? "R6" : "R5"));
        end
        cycle(1, next_ent(), 0);   // R4: dropped character
        check_all("R4");
        cycle(0, '0, 1);           // R4: accepted read clears overrun
        check_all("R4");
        drain("R5");
        cycle(0, '0, 1);           // R8: read while empty
        check_all("R8");
      end
    end

    // R9: write and read together at full capacity
    cfg_thr_code = 3'd5;
    for (int k = 0; k < 8; k++) cycle(1, next_ent(), 0);
    check_all("R3");
    cycle(1, next_ent(), 1);
    check_all("R9");
    cycle(1, next_ent(), 1);
    check_all("R9");
    drain("R9");

    // R7: single holding register when queueing is off
    cfg_fifo_en = 1'b0;
    cfg_thr_code = 3'd5;
    cfg_irq_en = 1'b1;
    #1;
    check_all("R7");
    cycle(1, next_ent(), 0);
    check_all("R7");
    cycle(1, next_ent(), 0);
    check_all("R7");
    cycle(1, next_ent(), 1);
    check_all("R7");
    cycle(0, '0, 1);
    check_all("R7");
    cycle(0, '0, 1);
    check_all("R8");

    // R2: mixed traffic with pointer wrap
    cfg_fifo_en = 1'b1;
    cfg_thr_code = 3'd3;
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[0] | lfsr[3], next_ent(), lfsr[1] & lfsr[5]);
      check_all("R2");
    end
    drain("R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule